// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of N boundary scan cells placed between a core's signals and the device pins. Every cell holds two flip-flops: a capture/shift stage and an update stage. The capture/shift stages are linked into one serial path. The path runs from `scan_in` at cell 0 to `scan_out`, which is taken from cell N-1. A test controller outside this block sequences the cells with four controls: a capture-stage clock enable, a shift select, an update strobe and a test-mode select.

All cells share one operation decoder, which has three named operations. OP_HOLD applies when `capture_en`=0, and every capture stage keeps its value. OP_CAPTURE applies when `capture_en`=1 and `shift_en`=0, and each capture stage samples its parallel input. OP_SHIFT applies when `capture_en`=1 and `shift_en`=1, and each capture stage takes the value of its upstream neighbour. The transitions run from any operation to any other on every clock edge, as the two controls select.

The update stage is a separate register. Shifting therefore never disturbs the parallel outputs while test mode drives them from the update stages. When test mode is off, each parallel output simply follows its parallel input.

Top module: `bscan_chain`

## Requirements
- R1: After reset is asserted, every capture stage and update stage holds 0. As a result, `scan_out` is 0, and `par_out` is 0 while `test_mode`=1.
- R2: While `test_mode`=0, `par_out[i]` equals `par_in[i]` for every bit, combinationally and regardless of the clock.
- R3: In OP_SHIFT, a clock edge moves `scan_in` into cell 0 and the value of cell i-1 into cell i. `scan_out` always shows the capture stage of cell N-1.
- R4: In OP_CAPTURE, a clock edge loads `par_in[i]` into the capture stage of cell i. After the capture, `scan_out` presents bit N-1 first, and bit N-1-k after k further shifts.
- R5: In OP_HOLD, the capture stages do not change, whatever `scan_in`, `shift_en` and `par_in` are doing.
- R6: A clock edge with `update_en`=1 copies every capture stage into its update stage. While `update_en`=0, the update stages keep their values.
- R7: While `test_mode`=1, `par_out[i]` shows the update stage of cell i. It stays unchanged through any number of shift or capture cycles that have no update.
- R8: Exactly N shifts load a full word. If the bits of a value V are shifted in most significant bit first, the update that follows makes `par_out` equal V.
- R9: When an update and a capture happen on the same edge, the update stage receives the capture-stage value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both stages |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_in | input | 1 | Serial input into cell 0 |
| shift_en | input | 1 | 1 selects the serial path, 0 selects the parallel inputs |
| capture_en | input | 1 | Clock enable for the capture/shift stages |
| update_en | input | 1 | Copies the capture stages into the update stages |
| test_mode | input | 1 | 1 drives the outputs from the update stages, 0 passes the inputs through |
| par_in | input | N | Parallel inputs, one per cell |
| par_out | output | N | Parallel outputs, one per cell |
| scan_out | output | 1 | Serial output from the capture stage of cell N-1 |

## Verification
The hardest case to reach from the ports is an update on the same edge as a capture, with the capture stages and update stages already holding different values. The stimulus first shifts a known word in and updates it. It then shifts a second word in without updating, and finally pulses update together with a capture of a third word, so the old and new values can be told apart at `par_out`. Stability of the outputs during shifting is checked on every cycle of every load, across a full sweep of all 2^N words.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_e;
endpackage

// File: rtl/bscan_opdec.sv
module bscan_opdec
    import bscan_pkg::*;
(
    input  logic     capture_en,
    input  logic     shift_en,
    output cell_op_e op
);
    always_comb begin
        unique case ({capture_en, shift_en})
            2'b11:   op = OP_SHIFT;
            2'b10:   op = OP_CAPTURE;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     mode,
    input  logic     si,
    input  logic     di,
    output logic     so,
    output logic     po
);
    logic cap_q;
    logic upd_q;

    // state registers: capture/shift stage and update stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            unique case (op)
                OP_SHIFT:   cap_q <= si;
                OP_CAPTURE: cap_q <= di;
                default:    cap_q <= cap_q;
            endcase
            if (upd_en) upd_q <= cap_q;
        end
    end

    // outputs
    always_comb begin
        so = cap_q;
        po = mode ? upd_q : di;
    end

    assert_shift_takes_si_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (so == $past(si)));

    assert_capture_takes_di_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE) |=> (so == $past(di)));

    assert_hold_keeps_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(so));

    assert_update_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (upd_q == $past(so)));

    assert_update_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(upd_q));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_in,
    input  logic         shift_en,
    input  logic         capture_en,
    input  logic         update_en,
    input  logic         test_mode,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] par_out,
    output logic         scan_out
);
    localparam int LINKS = N + 1;

    cell_op_e         op;
    logic [LINKS-1:0] link;

    bscan_opdec u_opdec (
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .op         (op)
    );

    assign link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        bscan_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .upd_en (update_en),
            .mode   (test_mode),
            .si     (link[i]),
            .di     (par_in[i]),
            .so     (link[i+1]),
            .po     (par_out[i])
        );
    end

    assign scan_out = link[N];

    assert_outputs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !update_en) |=> (!test_mode || $stable(par_out)));

    assert_tail_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && shift_en) |=> (scan_out == $past(link[N-1])));
endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_in = 1'b0;
    logic         shift_en = 1'b0;
    logic         capture_en = 1'b0;
    logic         update_en = 1'b0;
    logic         test_mode = 1'b0;
    logic [N-1:0] par_in = '0;
    logic [N-1:0] par_out;
    logic         scan_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bscan_chain #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .test_mode(test_mode),
        .par_in(par_in), .par_out(par_out), .scan_out(scan_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic si, input logic sh, input logic ce, input logic up);
        scan_in = si; shift_en = sh; capture_en = ce; update_en = up;
        @(posedge clk);
        #2;
        scan_in = 1'b0; shift_en = 1'b0; capture_en = 1'b0; update_en = 1'b0;
    endtask

    // shift value v in MSB first; with test_mode=1, par_out must stay at hold_v (R7)
    task automatic load(input logic [N-1:0] v, input logic [N-1:0] hold_v);
        for (int j = 0; j < N; j++) begin
            tick(v[N-1-j], 1'b1, 1'b1, 1'b0);
            check("R7 par_out stable while shifting", 32'(par_out), 32'(hold_v));
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cur;
        test_mode = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 scan_out after reset", 32'(scan_out), 32'd0);
        check("R1 par_out after reset", 32'(par_out), 32'd0);
        rst_n = 1'b1;
        #2;

        // R2: passthrough sweep
        test_mode = 1'b0;
        for (int v = 0; v < (1 << N); v++) begin
            par_in = N'(v);
            #1;
            check("R2 passthrough", 32'(par_out), 32'(v));
        end

        // R4 / R3: capture each word and unload it serially
        for (int v = 0; v < (1 << N); v++) begin
            par_in = N'(v);
            tick(1'b0, 1'b0, 1'b1, 1'b0);
            for (int k = 0; k < N; k++) begin
                check("R4 R3 unload bit", 32'(scan_out), 32'((v >> (N - 1 - k)) & 1));
                tick(1'b0, 1'b1, 1'b1, 1'b0);
            end
        end

        // R8 / R7 / R6: full load sweep with updates
        test_mode = 1'b1;
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        cur = '0;
        for (int v = 0; v < (1 << N); v++) begin
            par_in = ~N'(v);
            load(N'(v), cur);
            check("R6 no update yet", 32'(par_out), 32'(cur));
            tick(1'b0, 1'b0, 1'b0, 1'b1);
            check("R8 loaded word after N shifts", 32'(par_out), 32'(v));
            cur = N'(v);
        end

        // R5: hold with noisy inputs
        load(8'hA5, cur);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        cur = 8'hA5;
        for (int c = 0; c < 12; c++) begin
            par_in = N'(c * 37);
            tick(c[0], c[1], 1'b0, 1'b0);
            check("R5 scan_out held", 32'(scan_out), 32'd1);
        end
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 capture stages unchanged", 32'(par_out), 32'h0A5);

        // R9: update and capture on the same edge
        load(8'h3C, cur);
        par_in = 8'hC3;
        tick(1'b0, 1'b0, 1'b1, 1'b1);
        check("R9 update takes old capture value", 32'(par_out), 32'h03C);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 new capture value follows", 32'(par_out), 32'h0C3);

        // R2 again after test use
        test_mode = 1'b0;
        par_in = 8'h5A;
        #1;
        check("R2 passthrough after test", 32'(par_out), 32'h05A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule